// File: doc/BRIEF.md
# Overlap-Safe Rectangle Blit Sequencer

This block walks a rectangle on a linear frame buffer and produces, for each pixel, a read address into the source area and a write address into the destination area. It handles two operations: a copy from one rectangle to another, and a solid fill that only writes. The copy can have a source and destination that overlap. For that case the block picks a scan direction for each axis, so that no source pixel is overwritten before it has been read.

A command carries the source position, the destination position, the size, a fill flag and a 24-bit flag. Positions and sizes are each packed into one 32-bit word. In 24-bit mode each pixel is handled as three byte units. Horizontal values are therefore scaled by three, and the block reports the byte-lane rotation phase that the downstream pixel path needs.

Pixels leave the block through a valid/ready handshake. Each write is checked against a scissor window, and a write that falls outside the window is marked as suppressed. The scissor window can be loaded at run time.

Top module: `blit_seq`

## Requirements
- R1: A command accepted with a zero width or a zero height emits no pixel. `busy` stays low and `cmd_ready` stays high.
- R2: For a copy, when source y < destination y, rows are walked from the bottom upward. Both the source and destination row sequences then start at y + height − 1. Otherwise rows are walked from the top down, starting at y.
- R3: For a copy, when the (scaled) source x < the (scaled) destination x, columns are walked from right to left. Both column sequences then start at x + width − 1. Otherwise columns are walked from left to right, starting at x.
- R4: With `cmd_mode24` set, source x, destination x and width are multiplied by 3 before the direction choice and the start adjustment.
- R5: The rotation phase is computed from the adjusted starting destination x. It is (dx/4) mod 6 for a left-to-right walk and ((dx+2)/4) mod 6 for a right-to-left walk. `rot_en` equals the 24-bit flag of the running command, and `rot_phase` is 0 when that flag is clear.
- R6: Every packed word holds x (or width) in bits [31:16] and y (or height) in bits [15:0]. This applies to `cmd_src_xy`, `cmd_dst_xy`, `cmd_size_wh`, `sc_lt_xy` and `sc_rb_xy`.
- R7: After reset the scissor window is left 0, top 0, right VXRES−1 and bottom VYRES−1, with all bounds inclusive. A cycle with `sc_wr` high loads left/top from `sc_lt_xy` and right/bottom from `sc_rb_xy`. A pixel whose destination lies outside the window is still emitted, but with `px_wr_en` low.
- R8: A fill ignores the source position. It always walks top to bottom and left to right from the destination, covers every pixel of every row including the last one, and drives `px_rd_en` low.
- R9: Each address equals y × pitch × 8 + x, where `cfg_pitch` gives the line length in units of 8 engine units.
- R10: Exactly width × height pixels are emitted in row-major order, with columns varying fastest. While `px_valid` is high and `px_ready` is low, `px_valid` and both addresses hold.
- R11: `busy` rises in the cycle after a non-empty command is accepted. It falls in the cycle after the final pixel is accepted. `cmd_ready` is the inverse of `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be accepted (block idle) |
| cmd_fill | input | 1 | 1 = solid fill, 0 = copy |
| cmd_mode24 | input | 1 | 24-bit pixel mode |
| cmd_src_xy | input | 2*CW | Source position, x high / y low |
| cmd_dst_xy | input | 2*CW | Destination position, x high / y low |
| cmd_size_wh | input | 2*CW | Width high / height low |
| cfg_pitch | input | PW | Line pitch in units of 8 |
| sc_wr | input | 1 | Load scissor window |
| sc_lt_xy | input | 2*CW | Scissor left (high) / top (low) |
| sc_rb_xy | input | 2*CW | Scissor right (high) / bottom (low) |
| px_valid | output | 1 | Pixel address pair valid |
| px_ready | input | 1 | Downstream takes the pixel |
| px_rd_addr | output | AW | Source read address |
| px_rd_en | output | 1 | Read needed (low for fill) |
| px_wr_addr | output | AW | Destination write address |
| px_wr_en | output | 1 | Write allowed (inside scissor) |
| rot_phase | output | 3 | 24-bit byte-lane rotation phase |
| rot_en | output | 1 | Rotation in use |
| busy | output | 1 | Operation in progress |

## Verification
The assertions check on every cycle the properties that follow from the handshake alone:
- pixel addresses hold while stalled;
- `busy` drops only right after an accepted pixel;
- an empty command leaves the block idle;
- no command is taken while busy;
- the rotation phase stays below six.

The walk order, the direction chosen for each overlap case, the scaling by three, the address arithmetic and the scissor suppression can only be shown by the bench's scenarios. The bench compares every emitted pixel with a sequence it builds from the command.

// File: rtl/blit_pkg.sv
package blit_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } blit_st_e;

  // Byte-lane rotation phase from the adjusted starting destination x.
  function automatic logic [2:0] lane_phase(input logic [31:0] start_x,
                                            input logic        ltr);
    logic [31:0] b;
    b = ltr ? start_x : start_x + 32'd2;
    return 3'((b >> 2) % 32'd6);
  endfunction

endpackage

// File: rtl/blit_setup.sv
module blit_setup
  import blit_pkg::*;
#(
  parameter int CW = 16,
  parameter int XW = CW + 2
) (
  input  logic [CW-1:0] src_x,
  input  logic [CW-1:0] src_y,
  input  logic [CW-1:0] dst_x,
  input  logic [CW-1:0] dst_y,
  input  logic [CW-1:0] wid,
  input  logic [CW-1:0] hgt,
  input  logic          fill,
  input  logic          mode24,
  output logic [XW-1:0] sx0,
  output logic [XW-1:0] sy0,
  output logic [XW-1:0] dx0,
  output logic [XW-1:0] dy0,
  output logic [XW-1:0] w_eff,
  output logic [XW-1:0] h_eff,
  output logic          x_ltr,
  output logic          y_ttb,
  output logic [2:0]    rot,
  output logic          empty
);

  logic [XW-1:0] sxs, dxs, syx, dyx;
  logic [XW-1:0] one;

  always_comb begin
    one   = XW'(1);
    sxs   = mode24 ? XW'(src_x) + (XW'(src_x) << 1) : XW'(src_x);
    dxs   = mode24 ? XW'(dst_x) + (XW'(dst_x) << 1) : XW'(dst_x);
    w_eff = mode24 ? XW'(wid)   + (XW'(wid)   << 1) : XW'(wid);
    h_eff = XW'(hgt);
    syx   = XW'(src_y);
    dyx   = XW'(dst_y);
    empty = (wid == '0) || (hgt == '0);
    // Walk away from the overlap: bottom-up / right-to-left when moving down / right.
    y_ttb = fill || (src_y >= dst_y);
    x_ltr = fill || (sxs >= dxs);
    sy0   = y_ttb ? syx : syx + h_eff - one;
    dy0   = y_ttb ? dyx : dyx + h_eff - one;
    sx0   = x_ltr ? sxs : sxs + w_eff - one;
    dx0   = x_ltr ? dxs : dxs + w_eff - one;
    rot   = mode24 ? lane_phase(32'(dx0), x_ltr) : 3'd0;
  end

endmodule

// File: rtl/blit_walker.sv
module blit_walker #(
  parameter int XW = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          step,
  input  logic [XW-1:0] w,
  input  logic [XW-1:0] h,
  output logic [XW-1:0] col,
  output logic [XW-1:0] row,
  output logic          last
);

  logic [XW-1:0] col_n, row_n;
  logic          en;
  logic          row_end;

  always_comb begin
    row_end = (col == w - XW'(1));
    last    = row_end && (row == h - XW'(1));
    en      = start || step;
    col_n   = col;
    row_n   = row;
    if (start) begin
      col_n = '0;
      row_n = '0;
    end else if (step) begin
      if (row_end) begin
        col_n = '0;
        row_n = row + XW'(1);
      end else begin
        col_n = col + XW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col <= '0;
      row <= '0;
    end else if (en) begin
      col <= col_n;
      row <= row_n;
    end
  end

endmodule

// File: rtl/blit_addr.sv
module blit_addr #(
  parameter int XW = 18,
  parameter int PW = 10,
  parameter int AW = 32
) (
  input  logic [XW-1:0] base_x,
  input  logic [XW-1:0] base_y,
  input  logic [XW-1:0] col,
  input  logic [XW-1:0] row,
  input  logic          ltr,
  input  logic          ttb,
  input  logic [PW-1:0] pitch,
  output logic [XW-1:0] cur_x,
  output logic [XW-1:0] cur_y,
  output logic [AW-1:0] addr
);

  always_comb begin
    cur_x = ltr ? base_x + col : base_x - col;
    cur_y = ttb ? base_y + row : base_y - row;
    addr  = AW'(cur_y) * (AW'(pitch) << 3) + AW'(cur_x);
  end

endmodule

// File: rtl/blit_seq.sv
module blit_seq
  import blit_pkg::*;
#(
  parameter int CW    = 16,
  parameter int PW    = 10,
  parameter int AW    = 32,
  parameter int VXRES = 640,
  parameter int VYRES = 480
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic          cmd_fill,
  input  logic          cmd_mode24,
  input  logic [2*CW-1:0] cmd_src_xy,
  input  logic [2*CW-1:0] cmd_dst_xy,
  input  logic [2*CW-1:0] cmd_size_wh,
  input  logic [PW-1:0] cfg_pitch,
  input  logic          sc_wr,
  input  logic [2*CW-1:0] sc_lt_xy,
  input  logic [2*CW-1:0] sc_rb_xy,
  output logic          px_valid,
  input  logic          px_ready,
  output logic [AW-1:0] px_rd_addr,
  output logic          px_rd_en,
  output logic [AW-1:0] px_wr_addr,
  output logic          px_wr_en,
  output logic [2:0]    rot_phase,
  output logic          rot_en,
  output logic          busy
);

  localparam int XW = CW + 2;

  blit_st_e      state, state_n;
  logic [XW-1:0] s_sx0, s_sy0, s_dx0, s_dy0, s_w, s_h;
  logic          s_ltr, s_ttb, s_empty;
  logic [2:0]    s_rot;
  logic [XW-1:0] r_sx0, r_sy0, r_dx0, r_dy0, r_w, r_h;
  logic          r_ltr, r_ttb, r_fill, r_m24;
  logic [2:0]    r_rot;
  logic [CW-1:0] sc_l, sc_t, sc_r, sc_b;
  logic [XW-1:0] col, row, scx, scy, dcx, dcy;
  logic          last, accept, load, step;

  blit_setup #(.CW(CW), .XW(XW)) u_setup (
    .src_x (cmd_src_xy[2*CW-1:CW]), .src_y (cmd_src_xy[CW-1:0]),
    .dst_x (cmd_dst_xy[2*CW-1:CW]), .dst_y (cmd_dst_xy[CW-1:0]),
    .wid   (cmd_size_wh[2*CW-1:CW]), .hgt  (cmd_size_wh[CW-1:0]),
    .fill  (cmd_fill), .mode24 (cmd_mode24),
    .sx0 (s_sx0), .sy0 (s_sy0), .dx0 (s_dx0), .dy0 (s_dy0),
    .w_eff (s_w), .h_eff (s_h), .x_ltr (s_ltr), .y_ttb (s_ttb),
    .rot (s_rot), .empty (s_empty)
  );

  always_comb begin
    cmd_ready = (state == ST_IDLE);
    busy      = (state == ST_RUN);
    px_valid  = busy;
    accept    = cmd_valid && cmd_ready;
    load      = accept && !s_empty;
    step      = px_valid && px_ready;
    state_n   = state;
    case (state)
      ST_IDLE: if (load) state_n = ST_RUN;
      ST_RUN:  if (step && last) state_n = ST_IDLE;
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_sx0 <= '0; r_sy0 <= '0; r_dx0 <= '0; r_dy0 <= '0;
      r_w   <= '0; r_h   <= '0;
      r_ltr <= 1'b1; r_ttb <= 1'b1; r_fill <= 1'b0; r_m24 <= 1'b0;
      r_rot <= '0;
    end else if (load) begin
      r_sx0 <= s_sx0; r_sy0 <= s_sy0; r_dx0 <= s_dx0; r_dy0 <= s_dy0;
      r_w   <= s_w;   r_h   <= s_h;
      r_ltr <= s_ltr; r_ttb <= s_ttb; r_fill <= cmd_fill; r_m24 <= cmd_mode24;
      r_rot <= s_rot;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sc_l <= '0;
      sc_t <= '0;
      sc_r <= CW'(VXRES - 1);
      sc_b <= CW'(VYRES - 1);
    end else if (sc_wr) begin
      sc_l <= sc_lt_xy[2*CW-1:CW];
      sc_t <= sc_lt_xy[CW-1:0];
      sc_r <= sc_rb_xy[2*CW-1:CW];
      sc_b <= sc_rb_xy[CW-1:0];
    end
  end

  blit_walker #(.XW(XW)) u_walk (
    .clk (clk), .rst_n (rst_n), .start (load), .step (step),
    .w (r_w), .h (r_h), .col (col), .row (row), .last (last)
  );

  blit_addr #(.XW(XW), .PW(PW), .AW(AW)) u_src_addr (
    .base_x (r_sx0), .base_y (r_sy0), .col (col), .row (row),
    .ltr (r_ltr), .ttb (r_ttb), .pitch (cfg_pitch),
    .cur_x (scx), .cur_y (scy), .addr (px_rd_addr)
  );

  blit_addr #(.XW(XW), .PW(PW), .AW(AW)) u_dst_addr (
    .base_x (r_dx0), .base_y (r_dy0), .col (col), .row (row),
    .ltr (r_ltr), .ttb (r_ttb), .pitch (cfg_pitch),
    .cur_x (dcx), .cur_y (dcy), .addr (px_wr_addr)
  );

  always_comb begin
    px_rd_en  = !r_fill;
    px_wr_en  = (dcx >= XW'(sc_l)) && (dcx <= XW'(sc_r)) &&
                (dcy >= XW'(sc_t)) && (dcy <= XW'(sc_b));
    rot_phase = r_rot;
    rot_en    = r_m24;
  end

endmodule

// File: rtl/blit_seq_chk.sv
module blit_seq_chk #(
  parameter int CW = 16,
  parameter int AW = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cmd_valid,
  input logic            cmd_ready,
  input logic [2*CW-1:0] cmd_size_wh,
  input logic            busy,
  input logic            px_valid,
  input logic            px_ready,
  input logic [AW-1:0]   px_rd_addr,
  input logic [AW-1:0]   px_wr_addr,
  input logic [2:0]      rot_phase
);

  assert_empty_cmd_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready &&
     ((cmd_size_wh[2*CW-1:CW] == '0) || (cmd_size_wh[CW-1:0] == '0))) |=> !busy);

  assert_phase_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (rot_phase < 3'd6));

  assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (px_valid && !px_ready) |=> (px_valid && $stable(px_rd_addr) && $stable(px_wr_addr)));

  assert_busy_end_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(px_valid && px_ready));

  assert_no_cmd_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cmd_ready);

endmodule

bind blit_seq blit_seq_chk #(.CW(CW), .AW(AW)) u_chk (
  .clk (clk), .rst_n (rst_n), .cmd_valid (cmd_valid), .cmd_ready (cmd_ready),
  .cmd_size_wh (cmd_size_wh), .busy (busy), .px_valid (px_valid),
  .px_ready (px_ready), .px_rd_addr (px_rd_addr), .px_wr_addr (px_wr_addr),
  .rot_phase (rot_phase)
);

// File: tb/blit_seq_tb_top.sv
`timescale 1ns/1ps
module blit_seq_tb_top;

  localparam int PITCH = 4;
  localparam int VXR   = 640;
  localparam int VYR   = 480;

  logic        clk, rst_n;
  logic        cmd_valid, cmd_ready, cmd_fill, cmd_mode24;
  logic [31:0] cmd_src_xy, cmd_dst_xy, cmd_size_wh;
  logic [9:0]  cfg_pitch;
  logic        sc_wr;
  logic [31:0] sc_lt_xy, sc_rb_xy;
  logic        px_valid, px_ready, px_rd_en, px_wr_en, rot_en, busy;
  logic [31:0] px_rd_addr, px_wr_addr;
  logic [2:0]  rot_phase;

  int nchk = 0, nfail = 0;
  int scl = 0, sct = 0, scr = VXR - 1, scb = VYR - 1;

  blit_seq dut_i (
    .clk (clk), .rst_n (rst_n), .cmd_valid (cmd_valid), .cmd_ready (cmd_ready),
    .cmd_fill (cmd_fill), .cmd_mode24 (cmd_mode24), .cmd_src_xy (cmd_src_xy),
    .cmd_dst_xy (cmd_dst_xy), .cmd_size_wh (cmd_size_wh), .cfg_pitch (cfg_pitch),
    .sc_wr (sc_wr), .sc_lt_xy (sc_lt_xy), .sc_rb_xy (sc_rb_xy),
    .px_valid (px_valid), .px_ready (px_ready), .px_rd_addr (px_rd_addr),
    .px_rd_en (px_rd_en), .px_wr_addr (px_wr_addr), .px_wr_en (px_wr_en),
    .rot_phase (rot_phase), .rot_en (rot_en), .busy (busy)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Issue one command, collect every accepted pixel and compare with a model.
  task automatic do_op(input bit fill, input bit m24, input int sx, input int sy,
                       input int dx, input int dy, input int w, input int h,
                       input bit stall, input string tag);
    int sxs, dxs, ws, sx0, sy0, dx0, dy0, n, cyc, bad_a, bad_w, bad_r, bad_h;
    int ea, ew, ba, be, exr, got_rot, got_rot_en;
    bit ltr, ttb, held;
    logic [31:0] hr, hw;
    sxs = m24 ? sx * 3 : sx;
    dxs = m24 ? dx * 3 : dx;
    ws  = m24 ? w * 3 : w;
    ttb = fill || !(sy < dy);
    ltr = fill || !(sxs < dxs);
    sy0 = ttb ? sy : sy + h - 1;
    dy0 = ttb ? dy : dy + h - 1;
    sx0 = ltr ? sxs : sxs + ws - 1;
    dx0 = ltr ? dxs : dxs + ws - 1;
    exr = m24 ? ((ltr ? dx0 : dx0 + 2) / 4) % 6 : 0;
    @(negedge clk);
    cmd_valid   = 1'b1;
    cmd_fill    = fill;
    cmd_mode24  = m24;
    cmd_src_xy  = {16'(sx), 16'(sy)};
    cmd_dst_xy  = {16'(dx), 16'(dy)};
    cmd_size_wh = {16'(w), 16'(h)};
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(busy == ((w != 0) && (h != 0)), {tag, " R11 busy after accept"}, busy, (w != 0) && (h != 0));
    n = 0; cyc = 0; bad_a = 0; bad_w = 0; bad_r = 0; bad_h = 0;
    ba = 0; be = 0; got_rot = 0; got_rot_en = 0; held = 0; hr = '0; hw = '0;
    while (busy && cyc < 5000) begin
      if (held && (px_rd_addr != hr || px_wr_addr != hw || !px_valid)) bad_h++;
      px_ready = stall ? ((cyc % 3) != 1) : 1'b1;
      held = px_valid && !px_ready;
      hr = px_rd_addr; hw = px_wr_addr;
      if (cyc == 0) begin got_rot = int'(rot_phase); got_rot_en = int'(rot_en); end
      if (px_valid && px_ready) begin
        int r, c, ex, ey, erx, ery;
        r = n / ws; c = n % ws;
        ex  = ltr ? dx0 + c : dx0 - c;
        ey  = ttb ? dy0 + r : dy0 - r;
        erx = ltr ? sx0 + c : sx0 - c;
        ery = ttb ? sy0 + r : sy0 - r;
        ea = ey * PITCH * 8 + ex;
        ew = (ex >= scl && ex <= scr && ey >= sct && ey <= scb) ? 1 : 0;
        if (px_wr_addr != 32'(ea) || (!fill && px_rd_addr != 32'(ery * PITCH * 8 + erx))) begin
          if (bad_a == 0) begin ba = int'(px_wr_addr); be = ea; end
          bad_a++;
        end
        if (int'(px_wr_en) != ew) bad_w++;
        if (px_rd_en != !fill) bad_r++;
        n++;
      end
      @(negedge clk);
      cyc++;
    end
    px_ready = 1'b1;
    if (w != 0 && h != 0) begin
      chk(n == ws * h, {tag, " R10 pixel count"}, n, ws * h);
      chk(bad_a == 0, {tag, " R2 R3 R9 address sequence"}, ba, be);
      chk(bad_w == 0, {tag, " R7 scissor write enable"}, bad_w, 0);
      chk(bad_r == 0, {tag, " R8 read enable"}, bad_r, 0);
      chk(got_rot == exr, {tag, " R5 rotation phase"}, got_rot, exr);
      chk(got_rot_en == int'(m24), {tag, " R5 rotation enable"}, got_rot_en, m24);
      if (stall) chk(bad_h == 0, {tag, " R10 hold under stall"}, bad_h, 0);
    end else begin
      for (int i = 0; i < 4; i++) begin
        if (px_valid) bad_a++;
        @(negedge clk);
      end
      chk(bad_a == 0 && !busy, {tag, " R1 empty command no pixels"}, bad_a, 0);
    end
    chk(cmd_ready && !busy, {tag, " R11 idle at end"}, cmd_ready, 1);
  endtask

  task automatic t_reset();
    chk(cmd_ready == 1'b1, "R11 reset cmd_ready", cmd_ready, 1);
    chk(busy == 1'b0 && px_valid == 1'b0, "R10 reset idle outputs", busy, 0);
  endtask

  task automatic t_empty();
    do_op(0, 0, 1, 1, 2, 2, 0, 5, 0, "R1 zero width");
    do_op(1, 0, 1, 1, 2, 2, 4, 0, 0, "R1 zero height");
  endtask

  task automatic t_copy_dirs();
    do_op(0, 0, 2, 3, 5, 6, 4, 3, 0, "R2 R3 copy down-right");
    do_op(0, 0, 10, 8, 4, 2, 5, 4, 0, "R2 R3 copy up-left");
    do_op(0, 0, 9, 1, 3, 4, 3, 3, 0, "R2 R3 copy down-left");
    do_op(0, 0, 3, 3, 3, 3, 2, 2, 0, "R2 R3 copy in place");
  endtask

  task automatic t_fill();
    do_op(1, 0, 0, 0, 20, 5, 6, 3, 0, "R8 fill");
  endtask

  task automatic t_mode24();
    do_op(0, 1, 10, 2, 5, 2, 2, 2, 0, "R4 R5 24bit left-to-right");
    do_op(0, 1, 2, 4, 7, 1, 3, 2, 0, "R4 R5 24bit right-to-left");
    do_op(1, 1, 0, 0, 9, 0, 2, 1, 0, "R4 R5 R8 24bit fill");
  endtask

  task automatic t_scissor();
    do_op(1, 0, 0, 0, 636, 478, 8, 4, 0, "R7 default scissor");
    @(negedge clk);
    sc_wr = 1'b1;
    sc_lt_xy = {16'd10, 16'd4};
    sc_rb_xy = {16'd13, 16'd5};
    @(negedge clk);
    sc_wr = 1'b0;
    scl = 10; sct = 4; scr = 13; scb = 5;
    do_op(1, 0, 0, 0, 8, 3, 8, 4, 0, "R6 R7 programmed scissor");
  endtask

  task automatic t_stall();
    do_op(0, 0, 1, 1, 3, 2, 4, 3, 1, "R10 copy with stalls");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog R10 actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cmd_valid = 1'b0; cmd_fill = 1'b0; cmd_mode24 = 1'b0;
    cmd_src_xy = '0; cmd_dst_xy = '0; cmd_size_wh = '0;
    cfg_pitch = 10'(PITCH);
    sc_wr = 1'b0; sc_lt_xy = '0; sc_rb_xy = '0;
    px_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_empty();
    t_copy_dirs();
    t_fill();
    t_mode24();
    t_stall();
    t_scissor();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

endmodule